// File: doc/BRIEF.md
# DAC Command and Register Write Controller

This block is the command interpreter of a single-channel DAC that sits behind an I2C target. An I2C front end hands it whole received bytes together with strobes for start, stop and the falling SCL edge that closes each ACK slot. The block checks the address byte and decodes the command byte, which carries the command code, reference select, power-down mode and gain. It assembles the two data bytes into a left-justified code and answers every byte with an ACK or NACK decision.

Valid frames update a volatile DAC register and its configuration bits. The "write all" command also updates a nonvolatile copy of the same values. Reset reloads the volatile copy from that nonvolatile copy.

A nonvolatile write holds a ready flag low for a programmable number of cycles. In that window only volatile writes are served. Reads, general calls and further write-all commands are refused with a NACK.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Reset loads the DAC code and configuration outputs from the nonvolatile copy. That copy holds INIT_CODE and INIT_CFG at power-up and the last write-all values afterwards. Reset also sets ready_o to 1 and ack_o to 0.
- R2: An address byte whose bits [7:1] equal DEV_ADDR and whose bit 0 is 0 (write) gets ACK. Any other non-zero address with no match gets NACK, and every later byte of that frame gets NACK and changes nothing.
- R3: The command byte is split as [7:5] command code, [4:3] reference select (vref_o), [2:1] power-down (pd_o) and [0] gain (gain_o). An applied update drives these fields onto their outputs.
- R4: The third and fourth bytes form a 16-bit word, third byte high. dac_code_o takes the top DATA_W bits of that word (DATA_W from 8 to 16), and the remaining low bits are ignored.
- R5: Outputs change only on the ACK-fall strobe that closes the fourth byte. A stop that arrives before that strobe discards the frame, and a byte received outside a frame gets NACK.
- R6: After the fourth byte, further command, high and low bytes may follow without a new start. Each complete group produces its own update.
- R7: Command 3'b011 (write all) updates both copies and drives ready_o low for exactly BUSY_CYC cycles after the update edge.
- R8: While ready_o is 0, commands 3'b000, 3'b001 and 3'b010 are ACKed and applied to the volatile copy only.
- R9: While ready_o is 0, a write-all command byte gets NACK and changes neither copy.
- R10: An address byte of 8'h00 (general call), or a matching address with bit 0 set (read), gets NACK while ready_o is 0 and ACK while it is 1.
- R11: Command codes with bit 7 set (3'b1xx) get NACK, and the rest of the frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated-start condition seen (one-cycle strobe) |
| stop_i | input | 1 | Stop condition seen (one-cycle strobe) |
| byte_vld_i | input | 1 | byte_i holds a newly received byte (one-cycle strobe) |
| byte_i | input | 8 | Received byte |
| ack_fall_i | input | 1 | Falling SCL edge that ends the current ACK slot (one-cycle strobe) |
| ack_o | output | 1 | 1 = ACK the last byte, 0 = NACK |
| dac_code_o | output | DATA_W | Current volatile DAC code |
| vref_o | output | 2 | Reference select |
| pd_o | output | 2 | Power-down mode |
| gain_o | output | 1 | Gain select |
| ready_o | output | 1 | 1 = no nonvolatile write in progress |

## Verification
The ACK decision is registered on the byte strobe's edge, and the bench samples it at the following falling clock edge. Register outputs change on the edge that samples the ACK-fall strobe and are read at the next falling edge. The bench uses the same falling edge as cycle zero of the busy window and counts falling edges until ready_o returns, expecting exactly BUSY_CYC. Writes that land in the nonvolatile copy are seen at the ports by pulsing reset once the window has closed and comparing the reloaded outputs.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
package dac_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DHI, ST_DLO, ST_SKIP
  } frm_st_t;

  typedef struct packed {
    logic [1:0] vref;
    logic [1:0] pd;
    logic       gain;
  } dac_cfg_t;

  localparam logic [2:0] CMD_WR_ALL   = 3'b011;
  localparam logic [7:0] GEN_CALL_ADR = 8'h00;
endpackage

// File: rtl/dac_frame_fsm.sv
`timescale 1ns/1ps
module dac_frame_fsm
  import dac_cmd_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              ack_fall_i,
  input  logic              ready_i,
  output logic              ack_o,
  output logic              commit_o,
  output logic              commit_all_o,
  output logic [DATA_W-1:0] code_o,
  output dac_cfg_t          cfg_o,
  output frm_st_t           state_o
);
  frm_st_t           st;
  logic              pend, all_q;
  logic [7:0]        hi_q;
  logic [DATA_W-1:0] code_nx;

  generate
    if (DATA_W > 8) begin : g_wide
      assign code_nx = {hi_q, byte_i[7 -: (DATA_W-8)]};
    end else begin : g_narrow
      assign code_nx = hi_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ack_o  <= 1'b0;
      pend   <= 1'b0;
      all_q  <= 1'b0;
      hi_q   <= '0;
      code_o <= '0;
      cfg_o  <= '0;
    end else if (start_i) begin
      st   <= ST_ADDR;
      pend <= 1'b0;
    end else if (stop_i) begin
      st   <= ST_IDLE;
      pend <= 1'b0;
    end else begin
      if (ack_fall_i) pend <= 1'b0;
      if (byte_vld_i) begin
        unique case (st)
          ST_ADDR: begin
            if (byte_i[7:1] == DEV_ADDR && !byte_i[0]) begin
              ack_o <= 1'b1;
              st    <= ST_CMD;
            end else begin
              ack_o <= ready_i && (byte_i == GEN_CALL_ADR ||
                                   byte_i[7:1] == DEV_ADDR);
              st    <= ST_SKIP;
            end
          end
          ST_CMD: begin
            if (byte_i[7] || (byte_i[7:5] == CMD_WR_ALL && !ready_i)) begin
              ack_o <= 1'b0;
              st    <= ST_SKIP;
            end else begin
              ack_o <= 1'b1;
              cfg_o <= dac_cfg_t'(byte_i[4:0]);
              all_q <= (byte_i[7:5] == CMD_WR_ALL);
              st    <= ST_DHI;
            end
          end
          ST_DHI: begin
            ack_o <= 1'b1;
            hi_q  <= byte_i;
            st    <= ST_DLO;
          end
          ST_DLO: begin
            ack_o  <= 1'b1;
            code_o <= code_nx;
            pend   <= 1'b1;
            st     <= ST_CMD;
          end
          default: ack_o <= 1'b0;
        endcase
      end
    end
  end

  assign commit_o     = pend && ack_fall_i && !start_i && !stop_i;
  assign commit_all_o = commit_o && all_q;
  assign state_o      = st;
endmodule

// File: rtl/dac_nv_timer.sv
`timescale 1ns/1ps
module dac_nv_timer #(
  parameter int BUSY_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic ready_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start_i)      cnt <= CW'(BUSY_CYC);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign ready_o = (cnt == '0);
endmodule

// File: rtl/dac_reg_bank.sv
`timescale 1ns/1ps
module dac_reg_bank
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int INIT_CODE = 0,
  parameter int INIT_CFG  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vol_i,
  input  logic              wr_nv_i,
  input  logic [DATA_W-1:0] code_i,
  input  dac_cfg_t          cfg_i,
  output logic [DATA_W-1:0] code_o,
  output dac_cfg_t          cfg_o
);
  logic [DATA_W-1:0] nv_code = DATA_W'(INIT_CODE);
  dac_cfg_t          nv_cfg  = dac_cfg_t'(INIT_CFG);

  always_ff @(posedge clk) begin
    if (wr_nv_i) begin
      nv_code <= code_i;
      nv_cfg  <= cfg_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= nv_code;
      cfg_o  <= nv_cfg;
    end else if (wr_vol_i) begin
      code_o <= code_i;
      cfg_o  <= cfg_i;
    end
  end
endmodule

// File: rtl/dac_cmd_ctrl.sv
`timescale 1ns/1ps
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter logic [6:0] DEV_ADDR  = 7'h60,
  parameter int         BUSY_CYC  = 1000,
  parameter int         INIT_CODE = 0,
  parameter int         INIT_CFG  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              ack_fall_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [1:0]        vref_o,
  output logic [1:0]        pd_o,
  output logic              gain_o,
  output logic              ready_o
);
  logic              commit_w, commit_all_w;
  logic [DATA_W-1:0] new_code;
  dac_cfg_t          new_cfg, cur_cfg;
  frm_st_t           st_w;

  dac_frame_fsm #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .ack_fall_i(ack_fall_i),
    .ready_i(ready_o), .ack_o(ack_o), .commit_o(commit_w),
    .commit_all_o(commit_all_w), .code_o(new_code), .cfg_o(new_cfg),
    .state_o(st_w)
  );

  dac_nv_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst(rst), .start_i(commit_all_w), .ready_o(ready_o)
  );

  dac_reg_bank #(.DATA_W(DATA_W), .INIT_CODE(INIT_CODE), .INIT_CFG(INIT_CFG)) u_bank (
    .clk(clk), .rst(rst), .wr_vol_i(commit_w), .wr_nv_i(commit_all_w),
    .code_i(new_code), .cfg_i(new_cfg), .code_o(dac_code_o), .cfg_o(cur_cfg)
  );

  assign vref_o = cur_cfg.vref;
  assign pd_o   = cur_cfg.pd;
  assign gain_o = cur_cfg.gain;
endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module dac_cmd_ctrl_chk
  import dac_cmd_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              stop_i,
  input logic              byte_vld_i,
  input logic [7:0]        byte_i,
  input logic              ack_fall_i,
  input logic              ack_o,
  input logic [DATA_W-1:0] dac_code_o,
  input logic [1:0]        vref_o,
  input logic [1:0]        pd_o,
  input logic              gain_o,
  input logic              ready_o,
  input logic              commit_all_w,
  input frm_st_t           st_w
);
  // R5
  upd_only_on_ackfall_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_fall_i |=> $stable({dac_code_o, vref_o, pd_o, gain_o}));

  // R7
  busy_after_wrall_chk: assert property (@(posedge clk) disable iff (rst)
    commit_all_w |=> !ready_o);

  // R9
  no_wrall_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    commit_all_w |-> ready_o);

  // R2
  addr_mismatch_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !start_i && !stop_i && st_w == ST_ADDR &&
     byte_i[7:1] != DEV_ADDR && byte_i != GEN_CALL_ADR) |=> !ack_o);

  // R10
  busy_read_gc_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !start_i && !stop_i && st_w == ST_ADDR && !ready_o &&
     (byte_i == GEN_CALL_ADR || byte_i[0])) |=> !ack_o);

  // R11
  rsvd_cmd_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !start_i && !stop_i && st_w == ST_CMD && byte_i[7]) |=> !ack_o);
endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_chk (.*);

// File: tb/tb_dac_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_dac_cmd_ctrl;
  localparam int         DW   = 8;
  localparam logic [6:0] DEV  = 7'h60;
  localparam int         BUSY = 300;
  localparam logic [7:0] AW   = {DEV, 1'b0};
  localparam logic [7:0] AR   = {DEV, 1'b1};

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, stop_i = 0, byte_vld_i = 0, ack_fall_i = 0;
  logic [7:0] byte_i = '0;
  logic ack_o, gain_o, ready_o;
  logic [DW-1:0] dac_code_o;
  logic [1:0] vref_o, pd_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  dac_cmd_ctrl #(.DATA_W(DW), .DEV_ADDR(DEV), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .ack_fall_i(ack_fall_i),
    .ack_o(ack_o), .dac_code_o(dac_code_o), .vref_o(vref_o), .pd_o(pd_o),
    .gain_o(gain_o), .ready_o(ready_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int code, input int cfg);
    chk(req, {dac_code_o, vref_o, pd_o, gain_o}, (code << 5) | cfg);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit do_ack, output bit a);
    @(negedge clk) begin byte_i = b; byte_vld_i = 1; end
    @(negedge clk) begin byte_vld_i = 0; a = ack_o; ack_fall_i = do_ack; end
    @(negedge clk) ack_fall_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    @(negedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit a, a1, a2, a3;
    int k;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 power-up state
    chk_out("R1 init", 0, 0);
    chk("R1 ready", ready_o, 1);
    chk("R1 ack", ack_o, 0);

    // R2 foreign address ignored
    pulse_start();
    send(8'hA0, 1, a);  chk("R2 nack addr", a, 0);
    send(8'h1F, 1, a);  chk("R2 nack cmd", a, 0);
    send(8'hFF, 1, a);
    send(8'hFF, 1, a);  chk("R2 nack data", a, 0);
    chk_out("R2 unchanged", 0, 0);
    pulse_stop();

    // R3 R4 R6 sweep with repeated groups in one frame
    pulse_start();
    send(AW, 1, a); chk("R2 ack own addr", a, 1);
    for (int d = 0; d < 256; d++) begin
      logic [2:0] c;
      c = (d % 3 == 0) ? 3'b000 : (d % 3 == 1) ? 3'b001 : 3'b010;
      send({c, d[4:0]}, 1, a1);
      send(8'(d) ^ 8'h5A, 1, a2);
      send(~8'(d), 1, a3);
      chk("R6 acks", {a1, a2, a3}, 3'b111);
      chk_out("R3 R4 update", (d ^ 8'h5A) & 8'hFF, d & 5'h1F);
    end
    pulse_stop();
    // last: code 0xFF^0x5A = 0xA5, cfg 0x1F

    // R5 stop before last ACK fall
    pulse_start();
    send(AW, 1, a);
    send(8'h55, 1, a);
    send(8'h33, 1, a);
    send(8'h44, 0, a);
    pulse_stop();
    @(negedge clk) ack_fall_i = 1;
    @(negedge clk) ack_fall_i = 0;
    chk_out("R5 cut frame", 8'hA5, 5'h1F);
    send(8'h40, 1, a);  chk("R5 byte outside frame", a, 0);
    chk_out("R5 outside frame", 8'hA5, 5'h1F);

    // R7 R8 R9 R10 busy window
    pulse_start();
    send(AW, 1, a);
    send({3'b011, 5'h0A}, 1, a); chk("R7 wrall ack", a, 1);
    send(8'hC3, 1, a);
    send(8'h00, 1, a);
    chk("R7 busy", ready_o, 0);
    chk_out("R7 vol", 8'hC3, 5'h0A);
    send({3'b000, 5'h11}, 1, a1);
    send(8'h7E, 1, a2);
    send(8'h00, 1, a3);
    chk("R8 busy vol acks", {a1, a2, a3}, 3'b111);
    chk_out("R8 busy vol", 8'h7E, 5'h11);
    send({3'b011, 5'h04}, 1, a);  chk("R9 busy wrall nack", a, 0);
    send(8'h12, 1, a);
    send(8'h34, 1, a);
    chk_out("R9 busy wrall ignored", 8'h7E, 5'h11);
    pulse_stop();
    pulse_start();
    send(AR, 1, a);  chk("R10 busy read nack", a, 0);
    pulse_stop();
    pulse_start();
    send(8'h00, 1, a); chk("R10 busy gencall nack", a, 0);
    pulse_stop();
    while (!ready_o) @(negedge clk);
    pulse_start();
    send(AR, 1, a);  chk("R10 ready read ack", a, 1);
    pulse_stop();
    pulse_start();
    send(8'h00, 1, a); chk("R10 ready gencall ack", a, 1);
    pulse_stop();
    do_reset();
    chk_out("R1 R9 nv reload", 8'hC3, 5'h0A);

    // R7 exact busy length
    pulse_start();
    send(AW, 1, a);
    send({3'b011, 5'h1F}, 1, a);
    send(8'h01, 1, a);
    send(8'hEE, 1, a);
    k = 0;
    while (!ready_o && k < BUSY + 10) begin @(negedge clk); k++; end
    chk("R7 busy length", k, BUSY);
    pulse_stop();
    do_reset();
    chk_out("R1 nv reload 2", 8'h01, 5'h1F);

    // R11 reserved commands
    for (int c = 4; c < 8; c++) begin
      pulse_start();
      send(AW, 1, a);
      send({3'(c), 5'h00}, 1, a1);
      send(8'h99, 1, a2);
      send(8'h88, 1, a3);
      chk("R11 rsvd nack", {a1, a2, a3}, 3'b000);
      chk_out("R11 rsvd ignored", 8'h01, 5'h1F);
      pulse_stop();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule